// File: doc/BRIEF.md
# Descriptor-Ring Initialization Block Loader

This block brings a network controller's ring state up from memory. The host writes the block start address as two 16-bit halves, picks an entry width, then sets an init command. The loader reads three 32-bit words starting at that address over a master read port. It decodes them into an operating mode word, receive and transmit ring base addresses and ring lengths, and parks both descriptor cursors at their ring bases. It then raises a done flag, which becomes an interrupt when interrupts are enabled.

A start command enables the transmit and receive sections unless the loaded mode word disables them. A stop command turns both sections off. A later start re-parks both cursors at their ring bases without touching memory. When init and start arrive together, the sections wait until the fetch has completed. An error response on the read port abandons the load and raises an error flag. All sequencing decisions are taken on every second clock cycle.

Top module: `ringInitLoader`

## Requirements
- R1: After reset, rdReq, initDone, loadErr, irq, txOn, rxOn, modeWord and both descriptor pointers are zero.
- R2: An init fetch issues exactly three read requests, at {addr high half, addr low half} + 0, +4 and +8, each a full 32-bit word. rdReq and the word being read hold steady until rdValid.
- R3: With the entry-size select (config write, bit 0) at 0, entries are 16 bits wide. Word 0 bits 15:0 hold the mode. Words 1 (receive) and 2 (transmit) carry a 24-bit base in bits 23:0, zero-extended, and a log2 ring length in bits 31:28.
- R4: With the entry-size select at 1, entries are 32 bits wide. Word 0 carries the mode in bits 15:0, the receive log2 length in bits 23:20 and the transmit log2 length in bits 31:28. Words 1 and 2 are full 32-bit receive and transmit bases.
- R5: Each ring length output equals 2 to the power of its log2 field, limited to 2^MAX_LOG2 (512 by default).
- R6: Once a fetch completes, initDone is set and each descriptor pointer equals its ring base.
- R7: irq is high exactly when initDone is set and the interrupt-enable bit (command bit 4, taken from the latest command write) is 1. A command write with bit 3 set clears initDone and loadErr.
- R8: Command bit 2 (stop) clears txOn and rxOn. A later command bit 1 (start) sets txOn to the inverse of mode bit 0 and rxOn to the inverse of mode bit 1, and reloads both pointers to their bases, with no memory read.
- R9: A txStep or rxStep pulse while that section is on moves its pointer on by 16 bytes, wrapping to the base after the last descriptor. A step pulse while the section is off leaves the pointer unchanged.
- R10: Init and start written together (command bits 0 and 1) keep txOn and rxOn low for the whole fetch. The sections are enabled only once the load completes.
- R11: An rdErr response aborts the fetch. loadErr is set, initDone stays clear and no further reads are issued.
- R12: Sequencer state, and hence every rise of rdReq, changes only on alternate clock edges, counted from reset release: the second edge, the fourth, and so on.
- R13: A start command with no successfully loaded block leaves txOn and rxOn low and issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostSel | input | 2 | Write target: 0 address low, 1 address high, 2 command, 3 config |
| hostWrData | input | 16 | Host write data |
| txStep | input | 1 | Advance transmit cursor by one descriptor |
| rxStep | input | 1 | Advance receive cursor by one descriptor |
| rdReq | output | 1 | Memory read request, held until rdValid |
| rdAddr | output | 32 | Byte address of the requested word |
| rdValid | input | 1 | Read response valid, one cycle per request |
| rdData | input | 32 | Read response data |
| rdErr | input | 1 | Read response error, qualified by rdValid |
| modeWord | output | 16 | Loaded mode word (bit 0 transmit off, bit 1 receive off) |
| txRingBase | output | 32 | Transmit ring base |
| rxRingBase | output | 32 | Receive ring base |
| txRingLen | output | MAX_LOG2+1 | Transmit ring length in descriptors |
| rxRingLen | output | MAX_LOG2+1 | Receive ring length in descriptors |
| txDescPtr | output | 32 | Current transmit descriptor address |
| rxDescPtr | output | 32 | Current receive descriptor address |
| txOn | output | 1 | Transmit section enabled |
| rxOn | output | 1 | Receive section enabled |
| initDone | output | 1 | Block loaded |
| loadErr | output | 1 | Load aborted by a read error |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume a well-behaved memory side. It answers each request with one rdValid pulse, only while rdReq is high. The host leaves the start address and entry-size select alone while a fetch is running, and uses word-aligned start addresses. The bench's memory model replies once per observed request after a fixed two-cycle latency, from a three-word image built with the encodings in R3 and R4. The host tasks write the address and config registers only while the loader is idle.

// File: rtl/ringInitPkg.sv
package ringInitPkg;
  localparam int ADDR_W        = 32;
  localparam int WORD_W        = 32;
  localparam int HALF_W        = 16;
  localparam int FIELD_W       = 4;
  localparam int NARROW_BASE_W = 24;
  localparam int NUM_WORDS     = 3;
  localparam int IDX_W         = 2;
  localparam int SECTIONS      = 2;
  localparam int SEC_TX        = 0;
  localparam int SEC_RX        = 1;

  // command register bits
  localparam int CMD_INIT  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;
  localparam int CMD_ACK   = 3;
  localparam int CMD_IEN   = 4;

  // mode word bits that gate the sections
  localparam int MODE_TX_OFF = 0;
  localparam int MODE_RX_OFF = 1;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_CMD     = 2'd2,
    SEL_CFG     = 2'd3
  } hostSel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_COMMIT = 2'd2
  } seqState_e;

  typedef struct packed {
    logic             fetchBegin;
    logic             capture;
    logic             loadWord;
    logic [IDX_W-1:0] wordIdx;
    logic             abort;
    logic             commit;
    logic             restart;
    logic             stop;
    logic             busy;
  } ctrlStrobe_t;
endpackage

// File: rtl/ringCursor.sv
module ringCursor
  import ringInitPkg::*;
#(
  parameter int MAX_LOG2   = 9,
  parameter int DESC_SHIFT = 4,
  localparam int LEN_W     = MAX_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reload,
  input  logic               step,
  input  logic               active,
  input  logic [ADDR_W-1:0]  base,
  input  logic [FIELD_W-1:0] rawLog2,
  output logic [LEN_W-1:0]   ringLen,
  output logic [ADDR_W-1:0]  descPtr
);
  logic [FIELD_W-1:0] clampLog2;
  logic [LEN_W-1:0]   idx;

  assign clampLog2 = (rawLog2 > FIELD_W'(MAX_LOG2)) ? FIELD_W'(MAX_LOG2) : rawLog2;
  assign ringLen   = LEN_W'(1) << clampLog2;
  assign descPtr   = base + (ADDR_W'(idx) << DESC_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (reload) begin
      idx <= '0;
    end else if (step && active) begin
      idx <= (idx == ringLen - LEN_W'(1)) ? '0 : idx + LEN_W'(1);
    end
  end

  // R9: an enabled cursor always points inside its ring
  assert_idx_in_ring_R9: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx < ringLen));
endmodule

// File: rtl/initSequencer.sv
module initSequencer
  import ringInitPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        initCmd,
  input  logic        startCmd,
  input  logic        stopCmd,
  input  logic        blockValid,
  input  logic        rdValid,
  input  logic        rdErr,
  output logic        rdReq,
  output ctrlStrobe_t strobe
);
  seqState_e        state, nextState;
  logic [IDX_W-1:0] wordIdx, nextIdx;
  logic             phase;
  logic             tick;
  logic             gotResp, respErr;
  logic             initPend, startPend, stopPend;
  logic             clrInit, clrStart, clrStop, clrResp;

  assign tick  = phase;
  assign rdReq = (state == ST_FETCH) && !gotResp;

  always_comb begin
    nextState      = state;
    nextIdx        = wordIdx;
    clrInit        = 1'b0;
    clrStart       = 1'b0;
    clrStop        = 1'b0;
    clrResp        = 1'b0;
    strobe         = '0;
    strobe.capture = rdReq && rdValid;
    strobe.busy    = (state != ST_IDLE);
    strobe.wordIdx = wordIdx;
    if (tick) begin
      if (stopPend) begin
        strobe.stop = 1'b1;
        clrStop     = 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (initPend) begin
            strobe.fetchBegin = 1'b1;
            clrInit           = 1'b1;
            nextIdx           = '0;
            nextState         = ST_FETCH;
            if (stopPend) clrStart = 1'b1;
          end else if (startPend) begin
            clrStart       = 1'b1;
            strobe.restart = blockValid;
          end
        end
        ST_FETCH: begin
          if (stopPend) clrStart = 1'b1;
          if (gotResp) begin
            clrResp = 1'b1;
            if (respErr) begin
              strobe.abort = 1'b1;
              clrStart     = 1'b1;
              nextState    = ST_IDLE;
            end else begin
              strobe.loadWord = 1'b1;
              if (wordIdx == IDX_W'(NUM_WORDS - 1)) nextState = ST_COMMIT;
              else nextIdx = wordIdx + IDX_W'(1);
            end
          end
        end
        ST_COMMIT: begin
          strobe.commit = 1'b1;
          nextState     = ST_IDLE;
          if (startPend) begin
            clrStart       = 1'b1;
            strobe.restart = !stopPend;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wordIdx   <= '0;
      phase     <= 1'b0;
      gotResp   <= 1'b0;
      respErr   <= 1'b0;
      initPend  <= 1'b0;
      startPend <= 1'b0;
      stopPend  <= 1'b0;
    end else begin
      phase     <= ~phase;
      state     <= nextState;
      wordIdx   <= nextIdx;
      initPend  <= (initPend  && !clrInit)  || initCmd;
      startPend <= (startPend && !clrStart) || startCmd;
      stopPend  <= (stopPend  && !clrStop)  || stopCmd;
      if (clrResp) begin
        gotResp <= 1'b0;
        respErr <= 1'b0;
      end else if (strobe.capture) begin
        gotResp <= 1'b1;
        respErr <= rdErr;
      end
    end
  end

  // R12: the state only moves on the half-rate tick
  assert_half_rate_R12: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> $past(phase));

  // R2: an unanswered request stays up on the same word
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rdReq && !rdValid) |=> (rdReq && $stable(wordIdx)));
endmodule

// File: rtl/initStore.sv
module initStore
  import ringInitPkg::*;
#(
  parameter int MAX_LOG2   = 9,
  parameter int DESC_SHIFT = 4,
  localparam int LEN_W     = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [HALF_W-1:0] hostWrData,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] rdData,
  input  logic              txStep,
  input  logic              rxStep,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              blockValid,
  output logic [HALF_W-1:0] modeWord,
  output logic [ADDR_W-1:0] txRingBase,
  output logic [ADDR_W-1:0] rxRingBase,
  output logic [LEN_W-1:0]  txRingLen,
  output logic [LEN_W-1:0]  rxRingLen,
  output logic [ADDR_W-1:0] txDescPtr,
  output logic [ADDR_W-1:0] rxDescPtr,
  output logic              txOn,
  output logic              rxOn,
  output logic              initDone,
  output logic              loadErr,
  output logic              irq
);
  localparam int TOP_FIELD_LSB = WORD_W - FIELD_W;
  localparam int WIDE_RX_LSB   = HALF_W + FIELD_W;

  logic [HALF_W-1:0]  addrLo, addrHi;
  logic               wideSel, wideLatched, intEn;
  logic [ADDR_W-1:0]  fetchBase;
  logic [WORD_W-1:0]  holdData;
  logic [ADDR_W-1:0]  sectBase [SECTIONS];
  logic [FIELD_W-1:0] sectRaw  [SECTIONS];
  logic [LEN_W-1:0]   sectLen  [SECTIONS];
  logic [ADDR_W-1:0]  sectPtr  [SECTIONS];
  logic               sectOn   [SECTIONS];
  logic               sectStep [SECTIONS];
  logic               doneR, errR, validR;

  assign rdAddr = fetchBase + (ADDR_W'(strobe.wordIdx) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrLo      <= '0;
      addrHi      <= '0;
      wideSel     <= 1'b0;
      wideLatched <= 1'b0;
      intEn       <= 1'b0;
      fetchBase   <= '0;
      holdData    <= '0;
      modeWord    <= '0;
      doneR       <= 1'b0;
      errR        <= 1'b0;
      validR      <= 1'b0;
      for (int s = 0; s < SECTIONS; s++) begin
        sectBase[s] <= '0;
        sectRaw[s]  <= '0;
        sectOn[s]   <= 1'b0;
      end
    end else begin
      if (hostWrEn) begin
        case (hostSel)
          SEL_ADDR_LO: addrLo <= hostWrData;
          SEL_ADDR_HI: addrHi <= hostWrData;
          SEL_CFG:     wideSel <= hostWrData[0];
          SEL_CMD: begin
            intEn <= hostWrData[CMD_IEN];
            if (hostWrData[CMD_ACK]) begin
              doneR <= 1'b0;
              errR  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (strobe.capture) holdData <= rdData;
      if (strobe.fetchBegin) begin
        fetchBase   <= {addrHi, addrLo};
        wideLatched <= wideSel;
        doneR       <= 1'b0;
        errR        <= 1'b0;
        validR      <= 1'b0;
      end
      if (strobe.loadWord) begin
        case (strobe.wordIdx)
          IDX_W'(0): begin
            modeWord <= holdData[HALF_W-1:0];
            if (wideLatched) begin
              sectRaw[SEC_RX] <= holdData[WIDE_RX_LSB +: FIELD_W];
              sectRaw[SEC_TX] <= holdData[TOP_FIELD_LSB +: FIELD_W];
            end
          end
          IDX_W'(1): begin
            if (wideLatched) sectBase[SEC_RX] <= holdData;
            else begin
              sectBase[SEC_RX] <= ADDR_W'(holdData[NARROW_BASE_W-1:0]);
              sectRaw[SEC_RX]  <= holdData[TOP_FIELD_LSB +: FIELD_W];
            end
          end
          IDX_W'(2): begin
            if (wideLatched) sectBase[SEC_TX] <= holdData;
            else begin
              sectBase[SEC_TX] <= ADDR_W'(holdData[NARROW_BASE_W-1:0]);
              sectRaw[SEC_TX]  <= holdData[TOP_FIELD_LSB +: FIELD_W];
            end
          end
          default: ;
        endcase
      end
      if (strobe.abort) errR <= 1'b1;
      if (strobe.commit) begin
        doneR  <= 1'b1;
        validR <= 1'b1;
      end
      if (strobe.restart) begin
        sectOn[SEC_TX] <= ~modeWord[MODE_TX_OFF];
        sectOn[SEC_RX] <= ~modeWord[MODE_RX_OFF];
      end else if (strobe.stop || strobe.fetchBegin) begin
        sectOn[SEC_TX] <= 1'b0;
        sectOn[SEC_RX] <= 1'b0;
      end
    end
  end

  assign sectStep[SEC_TX] = txStep;
  assign sectStep[SEC_RX] = rxStep;

  for (genvar s = 0; s < SECTIONS; s++) begin : gCursor
    ringCursor #(
      .MAX_LOG2  (MAX_LOG2),
      .DESC_SHIFT(DESC_SHIFT)
    ) uCursor (
      .clk    (clk),
      .rst    (rst),
      .reload (strobe.commit || strobe.restart),
      .step   (sectStep[s]),
      .active (sectOn[s]),
      .base   (sectBase[s]),
      .rawLog2(sectRaw[s]),
      .ringLen(sectLen[s]),
      .descPtr(sectPtr[s])
    );
  end

  assign txRingBase = sectBase[SEC_TX];
  assign rxRingBase = sectBase[SEC_RX];
  assign txRingLen  = sectLen[SEC_TX];
  assign rxRingLen  = sectLen[SEC_RX];
  assign txDescPtr  = sectPtr[SEC_TX];
  assign rxDescPtr  = sectPtr[SEC_RX];
  assign txOn       = sectOn[SEC_TX];
  assign rxOn       = sectOn[SEC_RX];
  assign initDone   = doneR;
  assign loadErr    = errR;
  assign blockValid = validR;
  assign irq        = doneR && intEn;

  // R10: no section runs while the sequencer is busy with a fetch
  assert_busy_off_R10: assert property (@(posedge clk) disable iff (rst)
    strobe.busy |-> (!sectOn[SEC_TX] && !sectOn[SEC_RX]));

  // R11: an aborted load never reports completion
  assert_err_not_done_R11: assert property (@(posedge clk) disable iff (rst)
    errR |-> !doneR);
endmodule

// File: rtl/ringInitLoader.sv
module ringInitLoader
  import ringInitPkg::*;
#(
  parameter int MAX_LOG2   = 9,
  parameter int DESC_SHIFT = 4,
  localparam int LEN_W     = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [15:0]       hostWrData,
  input  logic              txStep,
  input  logic              rxStep,
  output logic              rdReq,
  output logic [31:0]       rdAddr,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  input  logic              rdErr,
  output logic [15:0]       modeWord,
  output logic [31:0]       txRingBase,
  output logic [31:0]       rxRingBase,
  output logic [LEN_W-1:0]  txRingLen,
  output logic [LEN_W-1:0]  rxRingLen,
  output logic [31:0]       txDescPtr,
  output logic [31:0]       rxDescPtr,
  output logic              txOn,
  output logic              rxOn,
  output logic              initDone,
  output logic              loadErr,
  output logic              irq
);
  ctrlStrobe_t strobe;
  logic        cmdWr, initCmd, startCmd, stopCmd, blockValid;

  assign cmdWr    = hostWrEn && (hostSel == SEL_CMD);
  assign initCmd  = cmdWr && hostWrData[CMD_INIT];
  assign startCmd = cmdWr && hostWrData[CMD_START];
  assign stopCmd  = cmdWr && hostWrData[CMD_STOP];

  initSequencer uSeq (
    .clk       (clk),
    .rst       (rst),
    .initCmd   (initCmd),
    .startCmd  (startCmd),
    .stopCmd   (stopCmd),
    .blockValid(blockValid),
    .rdValid   (rdValid),
    .rdErr     (rdErr),
    .rdReq     (rdReq),
    .strobe    (strobe)
  );

  initStore #(
    .MAX_LOG2  (MAX_LOG2),
    .DESC_SHIFT(DESC_SHIFT)
  ) uStore (
    .clk       (clk),
    .rst       (rst),
    .hostWrEn  (hostWrEn),
    .hostSel   (hostSel),
    .hostWrData(hostWrData),
    .strobe    (strobe),
    .rdData    (rdData),
    .txStep    (txStep),
    .rxStep    (rxStep),
    .rdAddr    (rdAddr),
    .blockValid(blockValid),
    .modeWord  (modeWord),
    .txRingBase(txRingBase),
    .rxRingBase(rxRingBase),
    .txRingLen (txRingLen),
    .rxRingLen (rxRingLen),
    .txDescPtr (txDescPtr),
    .rxDescPtr (rxDescPtr),
    .txOn      (txOn),
    .rxOn      (rxOn),
    .initDone  (initDone),
    .loadErr   (loadErr),
    .irq       (irq)
  );
endmodule

// File: tb/tb_ringInitLoader.sv
module tb_ringInitLoader;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LOG2   = 9;
  localparam int LEN_W      = MAX_LOG2 + 1;

  typedef struct packed {
    logic        wide;
    logic [3:0]  txLog2;
    logic [3:0]  rxLog2;
    logic [31:0] txBase;
    logic [31:0] rxBase;
    logic [31:0] blkAddr;
    logic        txDis;
    logic        rxDis;
    logic        withStart;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{1'b0, 4'd3,  4'd5,  32'h0012_3400, 32'hAB45_6700, 32'h0000_1000, 1'b0, 1'b0, 1'b1},
    '{1'b1, 4'd9,  4'd12, 32'h8000_0100, 32'hC000_0200, 32'h2000_0040, 1'b1, 1'b0, 1'b1},
    '{1'b1, 4'd0,  4'd1,  32'h0000_0800, 32'h0000_0A00, 32'h0000_3000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd15, 4'd2,  32'h0000_5000, 32'h00FF_F000, 32'h0001_0000, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostWrEn = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [15:0] hostWrData = 16'd0;
  logic txStep = 1'b0, rxStep = 1'b0;
  logic rdReq, rdValid, rdErr;
  logic [31:0] rdAddr, rdData;
  logic [15:0] modeWord;
  logic [31:0] txRingBase, rxRingBase, txDescPtr, rxDescPtr;
  logic [LEN_W-1:0] txRingLen, rxRingLen;
  logic txOn, rxOn, initDone, loadErr, irq;

  int checks = 0;
  int failures = 0;
  int readCount = 0;
  logic [31:0] readLog [64];
  logic [31:0] memBase = 32'd0;
  logic [31:0] memWords [3];
  logic        errEnable = 1'b0;
  logic [31:0] errAddr = 32'd0;
  int edgeCnt = 0;
  int riseCnt = 0;
  int oddRises = 0;
  logic prevReq = 1'b0;

  ringInitLoader dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostSel(hostSel), .hostWrData(hostWrData),
    .txStep(txStep), .rxStep(rxStep), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .rdErr(rdErr), .modeWord(modeWord), .txRingBase(txRingBase),
    .rxRingBase(rxRingBase), .txRingLen(txRingLen), .rxRingLen(rxRingLen),
    .txDescPtr(txDescPtr), .rxDescPtr(rxDescPtr), .txOn(txOn), .rxOn(rxOn),
    .initDone(initDone), .loadErr(loadErr), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) edgeCnt <= rst ? 0 : edgeCnt + 1;

  // half-rate monitor for R12
  always @(negedge clk) begin
    if (rdReq && !prevReq) begin
      riseCnt++;
      if (edgeCnt[0]) oddRises++;
    end
    prevReq = rdReq;
  end

  // memory model: one response per request, two cycles later
  initial begin
    rdValid = 1'b0;
    rdData  = 32'd0;
    rdErr   = 1'b0;
    forever begin
      @(negedge clk);
      if (rdReq) begin
        logic [31:0] off;
        if (readCount < 64) readLog[readCount] = rdAddr;
        readCount++;
        off = (rdAddr - memBase) >> 2;
        repeat (2) @(negedge clk);
        rdValid = 1'b1;
        rdData  = (off < 3) ? memWords[off[1:0]] : 32'hDEAD_BEEF;
        rdErr   = errEnable && (rdAddr == errAddr);
        @(negedge clk);
        rdValid = 1'b0;
        rdErr   = 1'b0;
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostSel    = sel;
    hostWrData = data;
    @(negedge clk);
    hostWrEn   = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitDone();
    for (int i = 0; i < 400; i++) begin
      if (initDone || loadErr) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] modeOf(input vec_t v);
    return {14'h0ABC, v.rxDis, v.txDis};
  endfunction

  function automatic logic [31:0] baseExp(input vec_t v, input logic [31:0] b);
    return v.wide ? b : {8'h00, b[23:0]};
  endfunction

  function automatic logic [LEN_W-1:0] lenExp(input logic [3:0] f);
    return LEN_W'(1) << ((f > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : f);
  endfunction

  task automatic loadImage(input vec_t v);
    memBase = v.blkAddr;
    if (v.wide) begin
      memWords[0] = {v.txLog2, 4'h0, v.rxLog2, 4'h0, modeOf(v)};
      memWords[1] = v.rxBase;
      memWords[2] = v.txBase;
    end else begin
      memWords[0] = {16'h0000, modeOf(v)};
      memWords[1] = {v.rxLog2, 4'h0, v.rxBase[23:0]};
      memWords[2] = {v.txLog2, 4'h0, v.txBase[23:0]};
    end
  endtask

  task automatic runVector(input vec_t v, input logic ien);
    int mark;
    string lay;
    lay = v.wide ? "R4" : "R3";
    loadImage(v);
    mark = readCount;
    hostWrite(2'd0, v.blkAddr[15:0]);
    hostWrite(2'd1, v.blkAddr[31:16]);
    hostWrite(2'd3, {15'd0, v.wide});
    hostWrite(2'd2, {11'd0, ien, 2'b00, v.withStart, 1'b1});
    for (int i = 0; i < 20; i++) begin
      if (rdReq) break;
      @(negedge clk);
    end
    check(!txOn && !rxOn, "R10", "sections off during fetch", {30'd0, rxOn, txOn}, 32'd0);
    waitDone();
    waitCycles(2);
    check(readCount - mark == 3, "R2", "read count", 32'(readCount - mark), 32'd3);
    for (int k = 0; k < 3; k++)
      check(readLog[mark + k] == v.blkAddr + 32'(4 * k), "R2", "read address",
            readLog[mark + k], v.blkAddr + 32'(4 * k));
    check(modeWord == modeOf(v), lay, "mode word", {16'd0, modeWord}, {16'd0, modeOf(v)});
    check(txRingBase == baseExp(v, v.txBase), lay, "tx base", txRingBase, baseExp(v, v.txBase));
    check(rxRingBase == baseExp(v, v.rxBase), lay, "rx base", rxRingBase, baseExp(v, v.rxBase));
    check(txRingLen == lenExp(v.txLog2), "R5", "tx length", 32'(txRingLen), 32'(lenExp(v.txLog2)));
    check(rxRingLen == lenExp(v.rxLog2), "R5", "rx length", 32'(rxRingLen), 32'(lenExp(v.rxLog2)));
    check(initDone && !loadErr, "R6", "done flag", {30'd0, loadErr, initDone}, 32'd1);
    check(txDescPtr == baseExp(v, v.txBase), "R6", "tx pointer", txDescPtr, baseExp(v, v.txBase));
    check(rxDescPtr == baseExp(v, v.rxBase), "R6", "rx pointer", rxDescPtr, baseExp(v, v.rxBase));
    check(txOn == (v.withStart && !v.txDis), "R10", "tx enable after load",
          {31'd0, txOn}, {31'd0, v.withStart && !v.txDis});
    check(rxOn == (v.withStart && !v.rxDis), "R10", "rx enable after load",
          {31'd0, rxOn}, {31'd0, v.withStart && !v.rxDis});
    check(irq == ien, "R7", "interrupt", {31'd0, irq}, {31'd0, ien});
  endtask

  initial begin
    int mark;
    logic [31:0] txB, rxB;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(!rdReq && !initDone && !loadErr && !irq && !txOn && !rxOn, "R1", "control outputs",
          {26'd0, rdReq, initDone, loadErr, irq, txOn, rxOn}, 32'd0);
    check(modeWord == 16'd0 && txDescPtr == 32'd0 && rxDescPtr == 32'd0, "R1", "data outputs",
          txDescPtr | rxDescPtr | {16'd0, modeWord}, 32'd0);

    // R13: start before any block is loaded
    hostWrite(2'd2, 16'h0002);
    waitCycles(12);
    check(!txOn && !rxOn, "R13", "sections stay off", {30'd0, rxOn, txOn}, 32'd0);
    check(readCount == 0, "R13", "no read issued", 32'(readCount), 32'd0);

    // table of layouts and modes
    for (int n = 0; n < 4; n++) begin
      runVector(VECS[n], 1'b1);
      hostWrite(2'd2, 16'h0008);
      waitCycles(1);
      check(!initDone && !irq, "R7", "ack clears done and interrupt",
            {30'd0, irq, initDone}, 32'd0);
    end

    // R7: interrupt masked
    runVector(VECS[0], 1'b0);
    check(initDone && !irq, "R7", "masked interrupt", {30'd0, irq, initDone}, 32'd1);

    // R9: stepping and wrap (tx ring of 8, rx ring of 32)
    txB = baseExp(VECS[0], VECS[0].txBase);
    rxB = baseExp(VECS[0], VECS[0].rxBase);
    @(negedge clk);
    txStep = 1'b1;
    repeat (9) @(negedge clk);
    txStep = 1'b0;
    rxStep = 1'b1;
    repeat (2) @(negedge clk);
    rxStep = 1'b0;
    check(txDescPtr == txB + 32'd16, "R9", "tx wrap", txDescPtr, txB + 32'd16);
    check(rxDescPtr == rxB + 32'd32, "R9", "rx step", rxDescPtr, rxB + 32'd32);

    // R8: stop, ignored step, restart without fetch
    hostWrite(2'd2, 16'h0004);
    waitCycles(4);
    check(!txOn && !rxOn, "R8", "stop clears sections", {30'd0, rxOn, txOn}, 32'd0);
    @(negedge clk);
    txStep = 1'b1;
    @(negedge clk);
    txStep = 1'b0;
    check(txDescPtr == txB + 32'd16, "R9", "step ignored while off", txDescPtr, txB + 32'd16);
    mark = readCount;
    hostWrite(2'd2, 16'h0002);
    waitCycles(4);
    check(txOn && rxOn, "R8", "start re-enables", {30'd0, rxOn, txOn}, 32'd3);
    check(txDescPtr == txB, "R8", "tx pointer reloaded", txDescPtr, txB);
    check(rxDescPtr == rxB, "R8", "rx pointer reloaded", rxDescPtr, rxB);
    check(readCount == mark, "R8", "no refetch", 32'(readCount - mark), 32'd0);

    // R11: read error on the second word
    loadImage(VECS[3]);
    errEnable = 1'b1;
    errAddr   = VECS[3].blkAddr + 32'd4;
    mark = readCount;
    hostWrite(2'd0, VECS[3].blkAddr[15:0]);
    hostWrite(2'd1, VECS[3].blkAddr[31:16]);
    hostWrite(2'd3, 16'h0000);
    hostWrite(2'd2, 16'h0013);
    waitDone();
    waitCycles(20);
    check(loadErr && !initDone && !irq, "R11", "error flags",
          {29'd0, irq, initDone, loadErr}, 32'd1);
    check(readCount - mark == 2, "R11", "reads stop at error", 32'(readCount - mark), 32'd2);
    check(!txOn && !rxOn, "R11", "sections off after abort", {30'd0, rxOn, txOn}, 32'd0);
    errEnable = 1'b0;
    hostWrite(2'd2, 16'h0008);
    waitCycles(1);
    check(!loadErr, "R7", "ack clears error", {31'd0, loadErr}, 32'd0);

    // R12: request rises only on even edges
    check(riseCnt > 0 && oddRises == 0, "R12", "odd-edge request rises",
          32'(oddRises), 32'd0);

    finishRun();
  end
endmodule